// File: doc/BRIEF.md
# Programmable Clock Control Channel

This block is one output channel of a clock generator. A single 32-bit control word, reached through a simple register write/read port, holds three settings: an output enable, a source index and an integer divisor. The channel takes the chosen source, divides its frequency by the divisor and drives the result on `clkOut` while the enable is set.

The channel runs on one fast reference clock. Each source clock comes in as a one-cycle tick strobe that is synchronous to that reference, and one tick is one input cycle. The output is a registered level. Software writes the whole word with a read-modify-write, so every writable bit reads back exactly as written.

A new word does not act at once. It is held as a shadow copy, and the datapath adopts it only at a point where the output is low and the current output period has finished. Because of this, a change to the source, the divisor or the enable never shortens a pulse.

Top module: `clkchan_top`

## Requirements
- R1: After reset the control word reads 0x0000_0001 (enable off, source 0, divide by 1) and `clkOut` is low.
- R2: The word layout is: bit 31 is the enable, bits 29:24 are the source index and bits 23:0 are the divisor. All of these bits read back as written. Bit 30 ignores writes and always reads 0.
- R3: The word sits at byte address CHAN_ID*4. A write to any other address leaves the word unchanged, and a read of any other address returns 0.
- R4: The source index picks `srcTick[index]` as the input clock. An index at or above NUM_SRC selects a source that never ticks.
- R5: For a divisor N of 2 or more, each output period lasts N input cycles. The output is high for the first floor(N/2) of those cycles and low for the rest.
- R6: A divisor of 1 passes the source through: `clkOut` is high for the one reference cycle after each tick.
- R7: A divisor of 0 holds the output low, with no edges.
- R8: When the enable bit is 0, `clkOut` stays low whatever the other fields hold.
- R9: A new word is adopted only when the output is low at a period boundary. A high pulse that is under way when the word is written keeps its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick | input | NUM_SRC | One-cycle tick per input-clock cycle, one bit per source |
| wrEn | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` |
| clkOut | output | 1 | Divided and gated output clock |

## Verification
The divider is driven from four sources that tick every 2, 3, 4 and 5 reference cycles. It is run with divisors 1, 2, 3, 4, 5 and 7, and with 0. Each setting is measured over a whole number of output periods, counting both the high cycles and the rising edges. Even and odd divisors differ in their high time, the source periods show which input was selected, and pass-through, stopped and gated settings each show their own fixed pattern. A separate test writes a new word in the middle of a long high pulse and checks that the pulse still lasts its full length.

// File: rtl/clkchan_pkg.sv
`timescale 1ns/1ps
package clkchan_pkg;
  localparam int WORD_W = 32;
  localparam int DIV_W  = 24;
  localparam int SEL_W  = 6;
  localparam int SEL_LO = 24;
  localparam int RSV_BIT = 30;
  localparam int EN_BIT  = 31;

  typedef struct packed {
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } chanCfg_t;

  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_0001;
endpackage

// File: rtl/clkchan_ctrl.sv
`timescale 1ns/1ps
module clkchan_ctrl
  import clkchan_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CHAN_ID = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output chanCfg_t          cfg
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CHAN_ID * 4);
  localparam logic [WORD_W-1:0] WR_MASK = ~(WORD_W'(1) << RSV_BIT);

  logic [WORD_W-1:0] wordQ;
  logic              hit;

  assign hit = (addr == MY_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= RESET_WORD;
    end else if (wrEn && hit) begin
      wordQ <= wrData & WR_MASK;
    end
  end

  assign rdData   = hit ? wordQ : '0;
  assign cfg.gate = wordQ[EN_BIT];
  assign cfg.sel  = wordQ[SEL_LO +: SEL_W];
  assign cfg.div  = wordQ[DIV_W-1:0];

  // R3: a write that does not hit this channel leaves the word as it was
  p_foreign_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && hit) |=> $stable(wordQ));

  // R2: the reserved bit never reads back as one
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[RSV_BIT] == 1'b0);
endmodule

// File: rtl/clkchan_dp.sv
`timescale 1ns/1ps
module clkchan_dp
  import clkchan_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  chanCfg_t           cfg,
  output logic               clkOut
);
  localparam int SPACE = 1 << SEL_W;

  logic [SPACE-1:0] tickPad;
  logic [SEL_W-1:0] actSel, effSel;
  logic [DIV_W-1:0] actDiv, effDiv, cntQ;
  logic             actGate, outQ, safe, tick;

  generate
    if (NUM_SRC < SPACE) begin : g_pad
      assign tickPad = {{(SPACE-NUM_SRC){1'b0}}, srcTick};
    end else begin : g_full
      assign tickPad = srcTick[SPACE-1:0];
    end
  endgenerate

  // a period boundary with the output low is the only point a new word lands
  assign safe   = (cntQ == '0) && !outQ;
  assign effSel = safe ? cfg.sel : actSel;
  assign effDiv = safe ? cfg.div : actDiv;
  assign tick   = tickPad[effSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSel  <= '0;
      actDiv  <= DIV_W'(1);
      actGate <= 1'b0;
      cntQ    <= '0;
      outQ    <= 1'b0;
    end else begin
      if (safe) begin
        actSel  <= cfg.sel;
        actDiv  <= cfg.div;
        actGate <= cfg.gate;
      end
      if (effDiv == '0) begin
        outQ <= 1'b0;
        cntQ <= '0;
      end else if (effDiv == DIV_W'(1)) begin
        outQ <= tick;
        cntQ <= '0;
      end else if (tick) begin
        outQ <= (cntQ < (effDiv >> 1));
        cntQ <= (cntQ == effDiv - DIV_W'(1)) ? '0 : cntQ + DIV_W'(1);
      end
    end
  end

  assign clkOut = outQ & actGate;

  // R9: the active settings change only from a low, period-aligned state
  p_load_safe_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(actDiv) || !$stable(actSel) || !$stable(actGate)) |->
      ($past(outQ) == 1'b0 && $past(cntQ) == '0));

  // R5: the phase counter stays inside the active period
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (actDiv > DIV_W'(1)) |-> (cntQ < actDiv));

  // R7: a stopped divider with no pending change keeps the output low
  p_stopped_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (actDiv == '0 && cfg.div == '0) |=> !outQ);

  // R6: in pass-through each selected tick shows up on the next cycle
  p_passthru_r6: assert property (@(posedge clk) disable iff (!rstN)
    (effDiv == DIV_W'(1) && tick) |=> outQ);
endmodule

// File: rtl/clkchan_top.sv
`timescale 1ns/1ps
module clkchan_top
  import clkchan_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  parameter int CHAN_ID = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               clkOut
);
  chanCfg_t cfg;

  clkchan_ctrl #(.ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cfg(cfg)
  );

  clkchan_dp #(.NUM_SRC(NUM_SRC)) dp_i (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .cfg(cfg), .clkOut(clkOut)
  );

  // R8: a disabled channel shows no high level once the enable has settled low
  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.gate && !clkOut) |=> !clkOut);
endmodule

// File: tb/clkchan_top_tb_top.sv
`timescale 1ns/1ps
module clkchan_top_tb_top;
  localparam int NUM_SRC = 64;
  localparam int ADDR_W  = 12;
  localparam int CHAN_ID = 3;
  localparam logic [ADDR_W-1:0] MY = ADDR_W'(CHAN_ID * 4);

  // sel, div, gate, window, expected high cycles, expected rising edges
  localparam int NV = 9;
  localparam int unsigned TBL [0:NV-1][0:5] = '{
    '{0, 1, 1,  8,  4, 4},  // R6 pass-through, source period 2
    '{1, 2, 1, 24, 12, 4},  // R5 even, period 3
    '{2, 3, 1, 48, 16, 4},  // R5 odd, period 4
    '{3, 4, 1, 80, 40, 4},  // R5 R4 period 5
    '{1, 5, 1, 60, 24, 4},  // R5 odd, period 3
    '{0, 7, 1, 56, 24, 4},  // R5 odd, period 2
    '{2, 0, 1, 40,  0, 0},  // R7 stopped
    '{3, 4, 0, 80,  0, 0},  // R8 gated off
    '{9, 2, 1, 40,  0, 0}   // R4 silent source
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_SRC-1:0] srcTick;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = MY;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic clkOut;

  int total = 0;
  int bad = 0;
  int unsigned tbCyc = 0;
  int runHi = 0;
  int lastHi = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkchan_top #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID)) dut_i (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .clkOut(clkOut)
  );

  // source i (i < 4) ticks every i+2 reference cycles; the rest never tick
  always @(negedge clk) tbCyc <= tbCyc + 1;
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      srcTick[i] = (i < 4) && ((tbCyc % (i + 2)) == 0);
  end

  always @(negedge clk) begin
    if (clkOut) runHi = runHi + 1;
    else begin
      if (runHi != 0) lastHi = runHi;
      runHi = 0;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = MY;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
    addr = MY;
  endtask

  task automatic measure(input int w, output int hi, output int ed);
    logic prev;
    hi = 0; ed = 0;
    @(negedge clk);
    prev = clkOut;
    repeat (w) begin
      @(negedge clk);
      if (clkOut) hi++;
      if (clkOut && !prev) ed++;
      prev = clkOut;
    end
  endtask

  function automatic logic [31:0] mkWord(int unsigned g, int unsigned s, int unsigned d);
    return {g[0], 1'b0, s[5:0], d[23:0]};
  endfunction

  initial begin
    #500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, ed;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(MY, d);
    check("R1 reset word", d, 32'h0000_0001);
    check("R1 reset output", clkOut, 0);

    // R2 readback and reserved bit
    wr(MY, 32'hFFFF_FFFF);
    rd(MY, d);
    check("R2 all ones readback", d, 32'hBFFF_FFFF);
    wr(MY, 32'h4000_0000);
    rd(MY, d);
    check("R2 reserved ignored", d, 32'h0000_0000);
    wr(MY, 32'h8A12_3456);
    rd(MY, d);
    check("R2 pattern readback", d, 32'h8A12_3456);

    // R3 foreign address
    wr(ADDR_W'(16), 32'h8000_0002);
    rd(MY, d);
    check("R3 foreign write ignored", d, 32'h8A12_3456);
    rd(ADDR_W'(16), d);
    check("R3 foreign read zero", d, 0);

    // table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      wr(MY, mkWord(TBL[v][2], TBL[v][0], TBL[v][1]));
      repeat (200) @(negedge clk);
      measure(int'(TBL[v][3]), hi, ed);
      check($sformatf("R5 vec%0d high cycles", v), hi, TBL[v][4]);
      check($sformatf("R5 vec%0d rising edges", v), ed, TBL[v][5]);
    end

    // R9: change the word mid-pulse; the pulse keeps its full length
    wr(MY, mkWord(1, 3, 4));
    repeat (200) @(negedge clk);
    @(negedge clk);
    while (clkOut) @(negedge clk);
    while (!clkOut) @(negedge clk);
    repeat (2) @(negedge clk);
    wr(MY, mkWord(1, 0, 2));
    while (clkOut) @(negedge clk);
    #1;
    check("R9 pulse length kept", lastHi, 10);
    repeat (100) @(negedge clk);
    measure(16, hi, ed);
    check("R9 new setting high", hi, 8);
    check("R9 new setting edges", ed, 4);

    // R8: enable cleared keeps output low
    wr(MY, mkWord(0, 0, 1));
    repeat (50) @(negedge clk);
    measure(20, hi, ed);
    check("R8 gated pass-through", hi, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule